// File: doc/BRIEF.md
# Two-Beam Vehicle Occupancy Counter

This block keeps a running count of the vehicles parked inside a lot. Two optical beams, A and B, cross the single lane of the lot. Beam A sits on the street side and beam B sits on the lot side. Each sensor line reads 1 while a vehicle blocks its beam and 0 while light reaches the receiver. The block reads the pair as a 2-bit code {A,B}. A sequence tracker follows the code as a vehicle passes. Only a complete crossing in one direction changes the stored occupancy.

A crossing into the lot runs through the codes 00, 10, 11, 01 and back to 00. A crossing out of the lot runs through 00, 01, 11, 10 and back to 00. Vehicles are slow compared with the clock, so each code may last any number of cycles. The tracker waits in a step for as long as the code stays the same. It accepts a step backwards when a vehicle reverses. It drops a partial crossing without touching the count. When the final return to 00 completes a crossing, the tracker sends a one-cycle step request with a direction to a saturating occupancy register.

The sensor lines are taken as already clean. Filtering for glitches and any display of the count are left to neighbouring logic.

Top module: `lot_occupancy_counter`

## Requirements
- R1: While rst_n is low the occupancy reads 0 and the tracker is idle. The first full inward crossing after reset raises the occupancy to 1.
- R2: An inward crossing (codes {A,B} = 10, 11, 01, then 00) raises the occupancy by exactly 1. The new value appears at the first rising edge where 00 is sampled after 01, and not earlier.
- R3: An outward crossing (codes 01, 11, 10, then 00) lowers the occupancy by exactly 1. The new value appears at the first rising edge where 00 is sampled after 10.
- R4: Each code may be held for any number of cycles, from 1 upwards, without changing the result of a crossing.
- R5: A return to 00 from any step other than the last step of a crossing leaves the occupancy unchanged and puts the tracker back in idle.
- R6: Inside a crossing, a code equal to the previous step's code moves the tracker back one step. A crossing that backs up and then goes forward to completion still counts once.
- R7: A nonzero code that is neither the current step, the next step nor the previous step (for example 10 followed by 01, or 11 straight from idle) abandons the crossing. All codes are then ignored until 00 is sampled.
- R8: An inward crossing with the occupancy at 1023 leaves it at 1023.
- R9: An outward crossing with the occupancy at 0 leaves it at 0.
- R10: Between two clock edges the occupancy changes by at most 1, and it changes only on a cycle that completes a crossing.
- R11: Driving rst_n low clears the occupancy at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| beam_a | input | 1 | Street-side beam, 1 = blocked |
| beam_b | input | 1 | Lot-side beam, 1 = blocked |
| occupancy | output | 10 | Vehicles currently inside the lot |

## Verification
The bench first uses directed crossings. These include a single inward and a single outward crossing, with the occupancy sampled on the cycle before and the cycle after the final 00. This confirms that the step lands on the right edge. Random runs then mix whole crossings, aborted crossings, reversing vehicles and illegal code jumps, each with a random hold time per code. Only the complete crossings may move the count, so these runs separate correct sequence tracking from a tracker that reacts to single codes. Filling to 1023 and draining below 0 show the saturation limits, and a reset pulse between clock edges shows that the clear is asynchronous.

// File: rtl/lot_occ_pkg.sv
package lot_occ_pkg;

  // Sensor code {A,B}; 1 = beam blocked
  localparam logic [1:0] CODE_CLEAR = 2'b00;
  localparam logic [1:0] CODE_A     = 2'b10;
  localparam logic [1:0] CODE_B     = 2'b01;
  localparam logic [1:0] CODE_AB    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // armed, beams clear
    ST_IN_A   = 3'd1,  // inward, street beam only
    ST_IN_AB  = 3'd2,  // inward, both beams
    ST_IN_B   = 3'd3,  // inward, lot beam only
    ST_OUT_B  = 3'd4,  // outward, lot beam only
    ST_OUT_AB = 3'd5,  // outward, both beams
    ST_OUT_A  = 3'd6,  // outward, street beam only
    ST_WAIT0  = 3'd7   // sequence broken, wait for clear
  } lot_state_e;

endpackage

// File: rtl/lot_seq_fsm.sv
module lot_seq_fsm
  import lot_occ_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       step_en,
  output logic       step_up
);

  lot_state_e state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    step_en  = 1'b0;
    step_up  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        unique case (code)
          CODE_CLEAR: state_nx = ST_IDLE;
          CODE_A:     state_nx = ST_IN_A;
          CODE_B:     state_nx = ST_OUT_B;
          CODE_AB:    state_nx = ST_WAIT0;
        endcase
      end
      ST_IN_A: begin
        unique case (code)
          CODE_CLEAR: state_nx = ST_IDLE;
          CODE_A:     state_nx = ST_IN_A;
          CODE_AB:    state_nx = ST_IN_AB;
          CODE_B:     state_nx = ST_WAIT0;
        endcase
      end
      ST_IN_AB: begin
        unique case (code)
          CODE_CLEAR: state_nx = ST_IDLE;
          CODE_AB:    state_nx = ST_IN_AB;
          CODE_B:     state_nx = ST_IN_B;
          CODE_A:     state_nx = ST_IN_A;
        endcase
      end
      ST_IN_B: begin
        unique case (code)
          CODE_CLEAR: begin
            state_nx = ST_IDLE;
            step_en  = 1'b1;
            step_up  = 1'b1;
          end
          CODE_B:     state_nx = ST_IN_B;
          CODE_AB:    state_nx = ST_IN_AB;
          CODE_A:     state_nx = ST_WAIT0;
        endcase
      end
      ST_OUT_B: begin
        unique case (code)
          CODE_CLEAR: state_nx = ST_IDLE;
          CODE_B:     state_nx = ST_OUT_B;
          CODE_AB:    state_nx = ST_OUT_AB;
          CODE_A:     state_nx = ST_WAIT0;
        endcase
      end
      ST_OUT_AB: begin
        unique case (code)
          CODE_CLEAR: state_nx = ST_IDLE;
          CODE_AB:    state_nx = ST_OUT_AB;
          CODE_A:     state_nx = ST_OUT_A;
          CODE_B:     state_nx = ST_OUT_B;
        endcase
      end
      ST_OUT_A: begin
        unique case (code)
          CODE_CLEAR: begin
            state_nx = ST_IDLE;
            step_en  = 1'b1;
            step_up  = 1'b0;
          end
          CODE_A:     state_nx = ST_OUT_A;
          CODE_AB:    state_nx = ST_OUT_AB;
          CODE_B:     state_nx = ST_WAIT0;
        endcase
      end
      ST_WAIT0: begin
        if (code == CODE_CLEAR) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  // R2: an upward step follows a cycle that sampled the lot-side-only code
  p_up_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up) |-> ($past(code) == CODE_B));

  // R3: a downward step follows a cycle that sampled the street-side-only code
  p_down_after_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up) |-> ($past(code) == CODE_A));

  // R5: a completed crossing always leaves the tracker idle
  p_idle_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (state == ST_IDLE));

  // R7: a broken sequence is held until the beams clear
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT0) && (code != CODE_CLEAR)) |=> (state == ST_WAIT0) && !step_en);

endmodule

// File: rtl/lot_occ_counter.sv
module lot_occ_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             step_up,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic at_max, at_min;
  assign at_max = (count == CNT_MAX);
  assign at_min = (count == CNT_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= CNT_MIN;
    end else if (step_en) begin
      if (step_up && !at_max)       count <= count + 1'b1;
      else if (!step_up && !at_min) count <= count - 1'b1;
    end
  end

  // R10: a change of the count is always a single unit
  p_unit_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |->
      ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

  // R10: without a step request the count holds
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(count));

  // R8: no wrap above the top
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && (count == CNT_MAX)) |=> (count == CNT_MAX));

  // R9: no wrap below zero
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && (count == CNT_MIN)) |=> (count == CNT_MIN));

endmodule

// File: rtl/lot_occupancy_counter.sv
module lot_occupancy_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beam_a,
  input  logic             beam_b,
  output logic [CNT_W-1:0] occupancy
);

  logic [1:0] code;
  logic       step_en;
  logic       step_up;

  assign code = {beam_a, beam_b};

  lot_seq_fsm u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (code),
    .step_en (step_en),
    .step_up (step_up)
  );

  lot_occ_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .step_up (step_up),
    .count   (occupancy)
  );

  // R1: the count is zero whenever reset is applied
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (occupancy == '0));

endmodule

// File: tb/lot_occupancy_counter_test.sv
module lot_occupancy_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             beam_a = 1'b0;
  logic             beam_b = 1'b0;
  logic [CNT_W-1:0] occupancy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int expected = 0;

  lot_occupancy_counter #(.CNT_W(CNT_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .beam_a    (beam_a),
    .beam_b    (beam_b),
    .occupancy (occupancy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sat_step(input int cur, input int delta);
    int n;
    n = cur + delta;
    if (n < 0) n = 0;
    if (n > CNT_MAX) n = CNT_MAX;
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Drive a code right after a falling edge and hold it for n rising edges
  task automatic hold(input logic [1:0] c, input int n);
    beam_a = c[1];
    beam_b = c[0];
    repeat (n) @(negedge clk);
  endtask

  task automatic crossing_in(input int d);
    hold(2'b10, d); hold(2'b11, d); hold(2'b01, d); hold(2'b00, d);
  endtask

  task automatic crossing_out(input int d);
    hold(2'b01, d); hold(2'b11, d); hold(2'b10, d); hold(2'b00, d);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hold(2'b00, 2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Random scenario; returns the expected change of the count
  task automatic scenario(input int kind, output int delta);
    logic [1:0] q[$];
    case (kind)
      0: begin q = '{2'b10, 2'b11, 2'b01}; delta = 1; end                          // R2
      1: begin q = '{2'b01, 2'b11, 2'b10}; delta = -1; end                         // R3
      2: begin q = '{2'b10, 2'b11}; delta = 0; end                                 // R5
      3: begin q = '{2'b01, 2'b11, 2'b10, 2'b11, 2'b01}; delta = 0; end            // R5, R6
      4: begin q = '{2'b10, 2'b11, 2'b10, 2'b11, 2'b01, 2'b11, 2'b01}; delta = 1; end // R6
      5: begin q = '{2'b10, 2'b01, 2'b11, 2'b01}; delta = 0; end                   // R7
      default: begin q = '{2'b11, 2'b01, 2'b11, 2'b10}; delta = 0; end             // R7
    endcase
    foreach (q[i]) hold(q[i], $urandom_range(1, 6));
    hold(2'b00, $urandom_range(1, 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd715));
    @(negedge clk);
    hold(2'b00, 2);
    check("R1 reset value", occupancy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", occupancy, 0);

    // R1/R2: first crossing in, edge-exact timing
    hold(2'b10, 3); hold(2'b11, 2); hold(2'b01, 4);
    check("R2 no step before final clear", occupancy, 0);
    hold(2'b00, 1);
    check("R2 step on first clear edge", occupancy, 1);
    hold(2'b00, 3);
    check("R10 held while clear", occupancy, 1);

    // R3: one crossing out, edge-exact
    hold(2'b01, 2); hold(2'b11, 5); hold(2'b10, 2);
    check("R3 no step before final clear", occupancy, 1);
    hold(2'b00, 1);
    check("R3 step on first clear edge", occupancy, 0);

    // R9: outward crossing at zero
    crossing_out(2);
    check("R9 hold at zero", occupancy, 0);

    // R4: long and single-cycle holds
    crossing_in(40);
    check("R4 long hold", occupancy, 1);
    crossing_in(1);
    check("R4 single-cycle hold", occupancy, 2);

    // R5: partial entry, return to clear
    hold(2'b10, 3); hold(2'b00, 2);
    check("R5 abort from first step", occupancy, 2);
    hold(2'b10, 2); hold(2'b11, 2); hold(2'b00, 2);
    check("R5 abort from middle step", occupancy, 2);

    // R7: illegal jump then tail of an entry, then a clean entry counts
    hold(2'b10, 2); hold(2'b01, 2); hold(2'b11, 2); hold(2'b01, 2); hold(2'b00, 2);
    check("R7 broken sequence ignored", occupancy, 2);
    crossing_in(2);
    check("R7 recovery after clear", occupancy, 3);

    // Random mix
    expected = 3;
    for (int i = 0; i < 300; i++) begin
      int delta;
      scenario($urandom_range(0, 6), delta);
      expected = sat_step(expected, delta);
      check("R2/R3/R5/R6/R7 random scenario", occupancy, expected);
    end

    // R8: fill to the top
    do_reset();
    check("R11 reset via pin", occupancy, 0);
    for (int i = 0; i < CNT_MAX; i++) crossing_in(1);
    check("R8 filled to top", occupancy, CNT_MAX);
    crossing_in(1);
    check("R8 hold at top", occupancy, CNT_MAX);
    crossing_out(1);
    check("R8 leave top", occupancy, CNT_MAX - 1);

    // R11: asynchronous clear between edges
    d = 2;
    #(d);
    rst_n = 1'b0;
    #1;
    check("R11 immediate clear", occupancy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    crossing_in(1);
    check("R1 count after reset", occupancy, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule